// File: doc/BRIEF.md
# Masked CAN identifier acceptance filter

This block decides whether the identifier of a received CAN frame is wanted. It holds a bank of identifier filters, each switched on or off by its own enable bit. Every filter stores a standard identifier, an extended identifier and a flag for the frame format it expects. Each filter can name one of a small pool of shared mask registers. Bit positions cleared in the chosen mask are left out of the comparison. A filter that names no mask demands an exact match.

A write-only register port programs the bank. Two registers are always reachable: a control word, whose bit 0 opens the filter window, and the filter enable word. The rest of the address range reaches the masks and filters only while the window is open. While it is closed, writes to that range pass through to an external port for a neighbouring register set.

Identifiers arrive with a one-cycle valid strobe. The block captures them and answers in the next cycle with an accept pulse and the index of the winning filter.

Top module: `can_id_accept`

## Requirements
- R1: After reset the window bit is 0, every enable bit is 0, every mask and filter word is 0, and accept and hit_idx are 0.
- R2: Address 0 holds the control word, whose bit 0 is the window bit. Address 1 holds the enable word, where bit n enables filter n. Both take writes whatever the window bit is, and neither is ever forwarded to the alt port.
- R3: While the window bit is 1, a write to address 2+m loads mask m (m = 0..2), with sid mask in bits [10:0], eid mask in bits [28:11] and the IDE mask in bit 29. In the same state, a write to address 8+n loads filter n (n = 0..15), with sid in [10:0], eid in [28:11], the extended flag in bit 29 and the mask select in [31:30]. These writes are not forwarded.
- R4: While the window bit is 0, a write to any address of 2 or above appears on alt_wr_en, alt_wr_addr and alt_wr_data in the same cycle, and it leaves every mask and filter unchanged.
- R5: A filter whose enable bit is 0 never produces a match.
- R6: A mask select of 0, 1 or 2 picks that mask. A standard identifier bit is compared only where the sid mask bit is 1, and any mismatch at a compared position rejects the filter.
- R7: A mask select of 3 compares all 11 sid bits and the IDE flag exactly, and all 18 eid bits as well when the frame is extended.
- R8: The frame's IDE flag must equal the filter's extended flag when the IDE mask bit is 1. The eid bits take part only when the frame's IDE flag is 1.
- R9: When several enabled filters match, hit_idx reports the lowest-numbered one.
- R10: accept and hit_idx are valid in the cycle after the id_valid strobe and only then. accept is a one-cycle pulse for each strobe, and hit_idx is 0 whenever accept is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| alt_wr_en | output | 1 | Forwarded write strobe while the window is closed |
| alt_wr_addr | output | 5 | Forwarded write address |
| alt_wr_data | output | 32 | Forwarded write data |
| id_valid | input | 1 | Identifier valid strobe |
| id_sid | input | 11 | Standard identifier of the frame |
| id_eid | input | 18 | Extended identifier bits of the frame |
| id_ide | input | 1 | Frame is extended-format |
| accept | output | 1 | One-cycle accept pulse |
| hit_idx | output | 4 | Index of the lowest matching enabled filter |

## Verification
The bench builds the block with its default parameters: sixteen filters, three masks and a two-bit mask select. Every filter index and every mask select value, including the no-mask code, can therefore be driven. The bench walks a match through each filter slot. It moves the enable set so that each index in turn is the lowest live one. For every mask it sweeps all 2048 standard identifiers, and it sweeps a range of extended identifiers around a masked nibble. The expected decision is computed from the mask arithmetic in each case.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
   localparam int SID_W  = 11;
   localparam int EID_W  = 18;
   localparam int MSEL_W = 2;
   localparam int DATA_W = SID_W + EID_W + 1 + MSEL_W;
   localparam int MASK_W = SID_W + EID_W + 1;

   typedef struct packed {
      logic [MSEL_W-1:0] msel;
      logic              ext;
      logic [EID_W-1:0]  eid;
      logic [SID_W-1:0]  sid;
   } filt_t;

   typedef struct packed {
      logic             ide_m;
      logic [EID_W-1:0] eid_m;
      logic [SID_W-1:0] sid_m;
   } mask_t;
endpackage

// File: rtl/cfr_regs.sv
module cfr_regs
   import cfr_pkg::*;
#(
   parameter int NUM_FILT  = 16,
   parameter int NUM_MASK  = 3,
   parameter int MASK_BASE = 2,
   parameter int FILT_BASE = 8,
   parameter int ADDR_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [NUM_FILT-1:0] filt_en,
   output mask_t             masks [NUM_MASK],
   output filt_t             filts [NUM_FILT],
   output logic              alt_wr_en,
   output logic [ADDR_W-1:0] alt_wr_addr,
   output logic [DATA_W-1:0] alt_wr_data
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);

   logic win_q;
   logic banked;
   logic loc_wr;

   assign banked = (wr_addr >= ADDR_W'(MASK_BASE));
   assign loc_wr = wr_en & banked & win_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q   <= 1'b0;
         filt_en <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_CTRL) win_q   <= wr_data[0];
         if (wr_addr == A_EN)   filt_en <= wr_data[NUM_FILT-1:0];
      end
   end

   for (genvar m = 0; m < NUM_MASK; m++) begin : g_mask
      always_ff @(posedge clk) begin
         if (!rst_n)
            masks[m] <= '0;
         else if (loc_wr && wr_addr == ADDR_W'(MASK_BASE + m))
            masks[m] <= mask_t'(wr_data[MASK_W-1:0]);
      end
   end

   for (genvar f = 0; f < NUM_FILT; f++) begin : g_filt
      always_ff @(posedge clk) begin
         if (!rst_n)
            filts[f] <= '0;
         else if (loc_wr && wr_addr == ADDR_W'(FILT_BASE + f))
            filts[f] <= filt_t'(wr_data);
      end

      assert_filt_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && win_q && wr_addr == ADDR_W'(FILT_BASE + f))
         |=> (filts[f] == filt_t'($past(wr_data))));

      assert_filt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !win_q && wr_addr == ADDR_W'(FILT_BASE + f))
         |=> (filts[f] == $past(filts[f])));
   end

   assign alt_wr_en   = wr_en & banked & ~win_q;
   assign alt_wr_addr = wr_addr;
   assign alt_wr_data = wr_data;

   assert_ctrl_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_EN) |=> (filt_en == $past(wr_data[NUM_FILT-1:0])));
endmodule

// File: rtl/cfr_cmp.sv
module cfr_cmp
   import cfr_pkg::*;
#(
   parameter int NUM_MASK = 3
) (
   input  logic             en,
   input  filt_t            filt,
   input  mask_t            masks [NUM_MASK],
   input  logic [SID_W-1:0] sid,
   input  logic [EID_W-1:0] eid,
   input  logic             ide,
   output logic             hit
);
   mask_t sel_m;
   logic  sid_ok, eid_ok, ide_ok;

   always_comb begin
      sel_m = '1;
      for (int k = 0; k < NUM_MASK; k++)
         if (filt.msel == MSEL_W'(k)) sel_m = masks[k];
   end

   assign sid_ok = ~|((sid ^ filt.sid) & sel_m.sid_m);
   assign eid_ok = ~ide | ~|((eid ^ filt.eid) & sel_m.eid_m);
   assign ide_ok = ~sel_m.ide_m | (ide == filt.ext);
   assign hit    = en & sid_ok & eid_ok & ide_ok;
endmodule

// File: rtl/cfr_pick.sv
module cfr_pick #(
   parameter int NUM_FILT = 16,
   parameter int HIT_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_FILT-1:0] match,
   output logic                any,
   output logic [HIT_W-1:0]    idx
);
   always_comb begin
      idx = '0;
      for (int i = NUM_FILT - 1; i >= 0; i--)
         if (match[i]) idx = HIT_W'(i);
   end
   assign any = |match;

   assert_pick_member_R9: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> match[idx]);

   assert_pick_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> ((match & ((NUM_FILT'(1) << idx) - NUM_FILT'(1))) == '0));
endmodule

// File: rtl/can_id_accept.sv
module can_id_accept
   import cfr_pkg::*;
#(
   parameter int NUM_FILT = 16,
   parameter int NUM_MASK = 3,
   localparam int MASK_BASE = 2,
   localparam int FILT_BASE = 1 << $clog2(MASK_BASE + NUM_MASK),
   localparam int ADDR_W    = $clog2(FILT_BASE + NUM_FILT),
   localparam int HIT_W     = $clog2(NUM_FILT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              alt_wr_en,
   output logic [ADDR_W-1:0] alt_wr_addr,
   output logic [DATA_W-1:0] alt_wr_data,
   input  logic              id_valid,
   input  logic [SID_W-1:0]  id_sid,
   input  logic [EID_W-1:0]  id_eid,
   input  logic              id_ide,
   output logic              accept,
   output logic [HIT_W-1:0]  hit_idx
);
   if (NUM_FILT < 2 || NUM_FILT > DATA_W) begin : g_bad_nfilt
      $error("NUM_FILT must lie between 2 and the data width");
   end
   if (NUM_MASK < 1 || NUM_MASK >= (1 << MSEL_W)) begin : g_bad_nmask
      $error("NUM_MASK must leave one mask select code for no mask");
   end

   logic [NUM_FILT-1:0] filt_en;
   mask_t               masks [NUM_MASK];
   filt_t               filts [NUM_FILT];
   logic [NUM_FILT-1:0] match;
   logic                any;
   logic [HIT_W-1:0]    idx;

   logic             vld_q;
   logic             ide_q;
   logic [SID_W-1:0] sid_q;
   logic [EID_W-1:0] eid_q;

   cfr_regs #(
      .NUM_FILT (NUM_FILT),
      .NUM_MASK (NUM_MASK),
      .MASK_BASE(MASK_BASE),
      .FILT_BASE(FILT_BASE),
      .ADDR_W   (ADDR_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .filt_en    (filt_en),
      .masks      (masks),
      .filts      (filts),
      .alt_wr_en  (alt_wr_en),
      .alt_wr_addr(alt_wr_addr),
      .alt_wr_data(alt_wr_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         ide_q <= 1'b0;
         sid_q <= '0;
         eid_q <= '0;
      end else begin
         vld_q <= id_valid;
         if (id_valid) begin
            ide_q <= id_ide;
            sid_q <= id_sid;
            eid_q <= id_eid;
         end
      end
   end

   for (genvar f = 0; f < NUM_FILT; f++) begin : g_cmp
      cfr_cmp #(.NUM_MASK(NUM_MASK)) u_cmp (
         .en   (filt_en[f]),
         .filt (filts[f]),
         .masks(masks),
         .sid  (sid_q),
         .eid  (eid_q),
         .ide  (ide_q),
         .hit  (match[f])
      );
   end

   cfr_pick #(.NUM_FILT(NUM_FILT), .HIT_W(HIT_W)) u_pick (
      .clk  (clk),
      .rst_n(rst_n),
      .match(match),
      .any  (any),
      .idx  (idx)
   );

   assign accept  = vld_q & any;
   assign hit_idx = accept ? idx : '0;

   assert_accept_after_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> $past(id_valid));

   assert_hit_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> filt_en[hit_idx]);

   assert_idle_idx_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |-> (hit_idx == '0));
endmodule

// File: tb/can_id_accept_test.sv
module can_id_accept_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        alt_wr_en;
   logic [4:0]  alt_wr_addr;
   logic [31:0] alt_wr_data;
   logic        id_valid = 1'b0;
   logic [10:0] id_sid = '0;
   logic [17:0] id_eid = '0;
   logic        id_ide = 1'b0;
   logic        accept;
   logic [3:0]  hit_idx;

   int total = 0;
   int bad = 0;
   logic       s_acc;
   logic [3:0] s_hit;

   can_id_accept uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .alt_wr_en(alt_wr_en), .alt_wr_addr(alt_wr_addr), .alt_wr_data(alt_wr_data),
      .id_valid(id_valid), .id_sid(id_sid), .id_eid(id_eid), .id_ide(id_ide),
      .accept(accept), .hit_idx(hit_idx)
   );

   always #10 clk = ~clk;

   task automatic chk(input logic ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [31:0] fword(input logic [1:0] ms, input logic ex,
                                         input logic [17:0] e, input logic [10:0] s);
      return {ms, ex, e, s};
   endfunction

   function automatic logic [31:0] mword(input logic im, input logic [17:0] e, input logic [10:0] s);
      return {2'b00, im, e, s};
   endfunction

   task automatic strobe(input logic [10:0] s, input logic [17:0] e, input logic ide);
      @(negedge clk);
      id_valid = 1'b1; id_sid = s; id_eid = e; id_ide = ide;
      @(negedge clk);
      id_valid = 1'b0;
      s_acc = accept; s_hit = hit_idx;
   endtask

   initial begin
      #(20 * 150000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(accept == 1'b0 && hit_idx == 4'd0, "R1 reset outputs", {accept, hit_idx}, 0);
      chk(alt_wr_en == 1'b0, "R1 alt idle", alt_wr_en, 0);
      strobe(11'h000, 18'h0, 1'b0);
      chk(s_acc == 1'b0, "R1 no filter enabled after reset", s_acc, 0);

      // R4: window closed, banked write is forwarded and ignored locally
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'd8; wr_data = fword(2'd3, 1'b0, 18'h0, 11'h123);
      #1;
      chk(alt_wr_en == 1'b1 && alt_wr_addr == 5'd8 && alt_wr_data == fword(2'd3, 1'b0, 18'h0, 11'h123),
          "R4 forward filter write", {alt_wr_en, alt_wr_addr}, {1'b1, 5'd8});
      @(negedge clk);
      wr_en = 1'b0;
      wr(5'd2, mword(1'b1, 18'h3FFFF, 11'h7FF));
      // R2: enable word is local, not forwarded
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'd1; wr_data = 32'h1;
      #1;
      chk(alt_wr_en == 1'b0, "R2 enable write not forwarded", alt_wr_en, 0);
      @(negedge clk);
      wr_en = 1'b0;
      strobe(11'h555, 18'h0, 1'b0);
      chk(s_acc == 1'b1 && s_hit == 4'd0, "R4 filter and mask left at reset value", s_acc, 1);

      // R2/R3: open window; banked writes stay local
      wr(5'd0, 32'h1);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'h0;
      #1;
      chk(alt_wr_en == 1'b0, "R3 banked write not forwarded when open", alt_wr_en, 0);
      @(negedge clk);
      wr_en = 1'b0;

      // R3/R7/R9: each filter holds a distinct exact identifier
      for (int i = 0; i < 16; i++)
         wr(5'(8 + i), fword(2'd3, 1'b0, 18'h0, 11'((i * 37 + 5) & 11'h7FF)));
      wr(5'd1, 32'hFFFF);
      for (int i = 0; i < 16; i++) begin
         strobe(11'((i * 37 + 5) & 11'h7FF), 18'h0, 1'b0);
         chk(s_acc == 1'b1 && s_hit == 4'(i), "R7 exact match per filter", {s_acc, s_hit}, {1'b1, 4'(i)});
      end
      @(negedge clk);
      chk(accept == 1'b0 && hit_idx == 4'd0, "R10 accept is a single pulse", {accept, hit_idx}, 0);
      strobe(11'h7FF, 18'h0, 1'b0);
      chk(s_acc == 1'b0, "R7 unmatched sid rejected", s_acc, 0);
      strobe(11'h005, 18'h0, 1'b1);
      chk(s_acc == 1'b0, "R7 exact compare includes IDE", s_acc, 0);

      // R10: no output in the strobe cycle itself
      @(negedge clk);
      id_valid = 1'b1; id_sid = 11'h005; id_eid = 18'h0; id_ide = 1'b0;
      #1;
      chk(accept == 1'b0, "R10 no accept before capture edge", accept, 0);
      @(negedge clk);
      id_valid = 1'b0;
      chk(accept == 1'b1 && hit_idx == 4'd0, "R10 accept one cycle after strobe", {accept, hit_idx}, {1'b1, 4'd0});

      // R9/R5: all filters identical, enable set picks the winner
      for (int i = 0; i < 16; i++)
         wr(5'(8 + i), fword(2'd3, 1'b0, 18'h0, 11'h2AA));
      for (int k = 0; k < 16; k++) begin
         wr(5'd1, 32'(16'h8000 | (16'h1 << k)));
         strobe(11'h2AA, 18'h0, 1'b0);
         chk(s_acc == 1'b1 && s_hit == 4'(k), "R9 lowest enabled filter wins", {s_acc, s_hit}, {1'b1, 4'(k)});
      end
      wr(5'd1, 32'h0);
      strobe(11'h2AA, 18'h0, 1'b0);
      chk(s_acc == 1'b0 && s_hit == 4'd0, "R5 all disabled", {s_acc, s_hit}, 0);

      // R6: sweep every standard identifier through each mask
      wr(5'd2, mword(1'b1, 18'h0, 11'h7F0));
      wr(5'd3, mword(1'b1, 18'h0, 11'h00F));
      wr(5'd4, mword(1'b1, 18'h0, 11'h555));
      wr(5'd1, 32'h1);
      for (int m = 0; m < 3; m++) begin
         logic [10:0] mv;
         mv = (m == 0) ? 11'h7F0 : (m == 1) ? 11'h00F : 11'h555;
         wr(5'd8, fword(2'(m), 1'b0, 18'h0, 11'h2A5));
         for (int s = 0; s < 2048; s++) begin
            logic exp;
            exp = (((11'(s) ^ 11'h2A5) & mv) == 11'h0);
            strobe(11'(s), 18'h0, 1'b0);
            chk(s_acc == exp, "R6 masked sid compare", s_acc, exp);
         end
      end

      // R8: extended compare with a masked low nibble
      wr(5'd3, mword(1'b1, 18'h3FFF0, 11'h7FF));
      wr(5'd8, fword(2'd1, 1'b1, 18'h12340, 11'h100));
      for (int j = 0; j < 256; j++) begin
         logic exp;
         exp = (j >= 32'h40 && j <= 32'h4F);
         strobe(11'h100, 18'h12300 + 18'(j), 1'b1);
         chk(s_acc == exp, "R8 masked eid compare", s_acc, exp);
      end
      strobe(11'h100, 18'h12340, 1'b0);
      chk(s_acc == 1'b0, "R8 IDE must agree when IDE mask set", s_acc, 0);
      wr(5'd3, mword(1'b0, 18'h3FFFF, 11'h7FF));
      strobe(11'h100, 18'h00001, 1'b0);
      chk(s_acc == 1'b1, "R8 eid skipped for standard frame, IDE ignored", s_acc, 1);
      strobe(11'h100, 18'h12341, 1'b1);
      chk(s_acc == 1'b0, "R8 eid mismatch rejects extended frame", s_acc, 0);
      strobe(11'h100, 18'h12340, 1'b1);
      chk(s_acc == 1'b1, "R8 eid match accepts extended frame", s_acc, 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule